// File: doc/BRIEF.md
# Multi-Source Sampled XOR Entropy Combiner

This block merges a set of free-running oscillator lines, which toggle with no relation to the system clock, into a single raw random bit on every clock. Each line first passes through its own short flip-flop synchronizer, so that a sampling flop caught mid-transition has time to settle before its value reaches the combining logic. The settled bits are folded by one exclusive-OR into a parity bit, which is registered and presented as the raw output together with a valid strobe.

Alongside the raw stream the block keeps a running tally of ones over fixed windows of valid output bits. At the close of each window it publishes the count and pulses a done flag for one clock. Dividing the count by the window length gives an estimate of the probability of a one, so an integrator can watch the bias of the source without capturing the stream. The oscillators, any whitening or conditioning, and statistical test suites sit outside this block.

Top module: `xor_entropy_combiner`

## Requirements
- R1: A synchronous active-high reset clears every synchronizer stage, the raw output register, the fill tracking, the window tally, `ones_o` and `win_done_o`; after a reset clock `valid_o`, `raw_o`, `win_done_o` and `ones_o` are all zero.
- R2: When `valid_o` is high after a clock edge, `raw_o` equals the XOR of all `NUM_SRC` bits of `osc_i` as sampled `SYNC_STAGES` edges before that edge (one output per clock, latency `SYNC_STAGES`+1 edges from sampling to output).
- R3: With `NUM_SRC` = 1 the raw output is the single oscillator line delayed by the same latency, with no inversion.
- R4: `valid_o` is low until `en_i` has been sampled high on `SYNC_STAGES`+1 consecutive edges out of reset; an edge that samples `en_i` low drops `valid_o` on that edge.
- R5: The window tally counts the ones among `WIN_LEN` consecutive valid raw bits; on the edge that consumes the last bit of a window, `ones_o` loads the count (0 to `WIN_LEN`, held in ceil(log2(`WIN_LEN`+1)) bits) and `win_done_o` is high for exactly one clock, and the next window starts empty.
- R6: Between window completions `ones_o` holds its last published value.
- R7: An edge that samples `en_i` low discards the partial window; counting restarts from zero with the next valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enables output qualification and window counting |
| osc_i | input | NUM_SRC | Asynchronous oscillator lines, one per source |
| raw_o | output | 1 | Registered XOR of the synchronized lines |
| valid_o | output | 1 | High when `raw_o` carries a qualified sample |
| ones_o | output | CNT_W | Ones count of the last completed window |
| win_done_o | output | 1 | One-clock pulse when `ones_o` is updated |

## Verification
The bench builds two copies side by side: one with five sources, a two-stage synchronizer and a sixteen-bit window, and one with a single source, a one-stage synchronizer and a seven-bit window. The first exercises the full reduction, the deeper latency and a window whose all-ones count needs the top bit of the counter; the second brings the single-source pass-through, the shorter latency and an odd window length within reach. Directed all-zero, all-one and alternating runs pin the parity and the count extremes, enable drops cut windows short, and a mid-run reset is followed by seeded random traffic.

// File: rtl/xec_pkg.sv
package xec_pkg;

   // Bits needed to hold any value from 0 to max_val inclusive.
   function automatic int unsigned cnt_bits(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

   // Bits needed to index positions 0 to n-1.
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/xec_sync_chain.sv
module xec_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_i,
   output logic sync_o
);

   generate
      if (STAGES == 1) begin : g_single
         logic cap_q;
         always_ff @(posedge clk) begin
            if (rst) cap_q <= 1'b0;
            else     cap_q <= async_i;
         end
         assign sync_o = cap_q;
      end else begin : g_chain
         logic [STAGES-1:0] shf_q;
         always_ff @(posedge clk) begin
            if (rst) shf_q <= '0;
            else     shf_q <= {shf_q[STAGES-2:0], async_i};
         end
         assign sync_o = shf_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/xec_xor_reduce.sv
module xec_xor_reduce #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] bits_i,
   output logic             par_o
);

   generate
      if (WIDTH == 1) begin : g_pass
         assign par_o = bits_i[0];
      end else begin : g_tree
         // Balanced pairwise tree stored level by level in a flat vector.
         localparam int NODES = 2 * WIDTH - 1;
         logic [NODES-1:0] node;
         assign node[WIDTH-1:0] = bits_i;
         for (genvar k = 0; k < WIDTH - 1; k++) begin : g_node
            assign node[WIDTH + k] = node[2*k] ^ node[2*k + 1];
         end
         assign par_o = node[NODES-1];
      end
   endgenerate

endmodule

// File: rtl/xec_bias_window.sv
module xec_bias_window #(
   parameter int WIN_LEN = 256,
   parameter int CNT_W   = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en_i,
   input  logic             bit_vld_i,
   input  logic             bit_i,
   output logic [CNT_W-1:0] ones_o,
   output logic             done_o
);

   localparam int POS_W = xec_pkg::idx_bits(WIN_LEN);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(WIN_LEN - 1);

   logic [POS_W-1:0] pos_q;
   logic [CNT_W-1:0] acc_q;
   logic [CNT_W-1:0] acc_nxt;

   assign acc_nxt = acc_q + CNT_W'(bit_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q  <= '0;
         acc_q  <= '0;
         ones_o <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!en_i) begin
            pos_q <= '0;
            acc_q <= '0;
         end else if (bit_vld_i) begin
            if (pos_q == LAST_POS) begin
               ones_o <= acc_nxt;
               done_o <= 1'b1;
               pos_q  <= '0;
               acc_q  <= '0;
            end else begin
               pos_q <= pos_q + 1'b1;
               acc_q <= acc_nxt;
            end
         end
      end
   end

endmodule

// File: rtl/xor_entropy_combiner.sv
module xor_entropy_combiner #(
   parameter  int NUM_SRC     = 4,
   parameter  int SYNC_STAGES = 2,
   parameter  int WIN_LEN     = 256,
   localparam int CNT_W       = xec_pkg::cnt_bits(WIN_LEN)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en_i,
   input  logic [NUM_SRC-1:0] osc_i,
   output logic               raw_o,
   output logic               valid_o,
   output logic [CNT_W-1:0]   ones_o,
   output logic               win_done_o
);

   localparam int LATENCY = SYNC_STAGES + 1;
   localparam int FILL_W  = xec_pkg::cnt_bits(LATENCY);
   localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(LATENCY);

   // Elaboration-time legality checks.
   generate
      if (SYNC_STAGES < 1 || SYNC_STAGES > 2) begin : g_bad_stages
         $error("SYNC_STAGES must be 1 or 2");
      end
      if (NUM_SRC < 1) begin : g_bad_src
         $error("NUM_SRC must be at least 1");
      end
      if (WIN_LEN < 2) begin : g_bad_win
         $error("WIN_LEN must be at least 2");
      end
   endgenerate

   logic [NUM_SRC-1:0] sync_bits;
   logic               parity;
   logic               raw_q;
   logic [FILL_W-1:0]  fill_q;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      xec_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst     (rst),
         .async_i (osc_i[i]),
         .sync_o  (sync_bits[i])
      );
   end

   xec_xor_reduce #(.WIDTH(NUM_SRC)) u_xor (
      .bits_i (sync_bits),
      .par_o  (parity)
   );

   always_ff @(posedge clk) begin
      if (rst) raw_q <= 1'b0;
      else     raw_q <= parity;
   end

   // Counts consecutive enabled edges until the pipeline holds fresh data.
   always_ff @(posedge clk) begin
      if (rst || !en_i)          fill_q <= '0;
      else if (fill_q != FILL_FULL) fill_q <= fill_q + 1'b1;
   end

   assign raw_o   = raw_q;
   assign valid_o = (fill_q == FILL_FULL);

   xec_bias_window #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_win (
      .clk       (clk),
      .rst       (rst),
      .en_i      (en_i),
      .bit_vld_i (valid_o),
      .bit_i     (raw_q),
      .ones_o    (ones_o),
      .done_o    (win_done_o)
   );

endmodule

// File: rtl/xec_checker.sv
module xec_checker #(
   parameter int NUM_SRC     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 9
) (
   input logic               clk,
   input logic               rst,
   input logic               en_i,
   input logic [NUM_SRC-1:0] osc_i,
   input logic               raw_o,
   input logic               valid_o,
   input logic [CNT_W-1:0]   ones_o,
   input logic               win_done_o
);

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!valid_o && !win_done_o && ones_o == '0 && !raw_o));

   // R2
   raw_parity_chk: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> (raw_o == $past(^osc_i, SYNC_STAGES + 1)));

   // R4
   valid_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
      !en_i |=> !valid_o);

   // R4
   valid_after_en_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(valid_o) |-> $past(en_i));

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      win_done_o |=> !win_done_o);

   // R6
   ones_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !win_done_o |-> $stable(ones_o));

endmodule

bind xor_entropy_combiner xec_checker #(
   .NUM_SRC     (NUM_SRC),
   .SYNC_STAGES (SYNC_STAGES),
   .CNT_W       (CNT_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .en_i       (en_i),
   .osc_i      (osc_i),
   .raw_o      (raw_o),
   .valid_o    (valid_o),
   .ones_o     (ones_o),
   .win_done_o (win_done_o)
);

// File: tb/xor_entropy_combiner_tb.sv
module xor_entropy_combiner_tb;

   localparam int NA = 5, SA = 2, WA = 16, CWA = 5;
   localparam int NB = 1, SB = 1, WB = 7,  CWB = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   logic [NA-1:0] osc_a = '0;
   logic [NB-1:0] osc_b;

   logic raw_a, val_a, done_a;
   logic [CWA-1:0] ones_a;
   logic raw_b, val_b, done_b;
   logic [CWB-1:0] ones_b;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   string win_tag = "R5";

   assign osc_b = osc_a[0:0];

   always #5 clk = ~clk;

   xor_entropy_combiner #(.NUM_SRC(NA), .SYNC_STAGES(SA), .WIN_LEN(WA)) u_dut (
      .clk(clk), .rst(rst), .en_i(en), .osc_i(osc_a),
      .raw_o(raw_a), .valid_o(val_a), .ones_o(ones_a), .win_done_o(done_a));

   xor_entropy_combiner #(.NUM_SRC(NB), .SYNC_STAGES(SB), .WIN_LEN(WB)) u_dut_n1 (
      .clk(clk), .rst(rst), .en_i(en), .osc_i(osc_b),
      .raw_o(raw_b), .valid_o(val_b), .ones_o(ones_b), .win_done_o(done_b));

   // Reference model state, A = five-source copy, B = single-source copy.
   logic [NA-1:0] ha [0:2];
   logic          hb [0:1];
   int fa = 0, fb = 0;
   logic ev_a = 0, er_a = 0, ed_a = 0;
   logic ev_b = 0, er_b = 0, ed_b = 0;
   int eo_a = 0, eo_b = 0, cnt_a = 0, cnt_b = 0, tal_a = 0, tal_b = 0;
   logic last_rst = 1'b1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic int min_i(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   task automatic cycle(input logic r, input logic e, input logic [NA-1:0] s);
      logic pv, pr;
      @(negedge clk);
      // compare outputs left by the previous edge
      if (last_rst) begin
         check(!val_a && !raw_a && !done_a && ones_a == 0, "R1",
               {val_a, raw_a, done_a, ones_a}, 0);
         check(!val_b && !raw_b && !done_b && ones_b == 0, "R1",
               {val_b, raw_b, done_b, ones_b}, 0);
      end else begin
         check(val_a == ev_a, "R4", val_a, ev_a);
         check(val_b == ev_b, "R4", val_b, ev_b);
         if (ev_a) check(raw_a == er_a, "R2", raw_a, er_a);
         if (ev_b) check(raw_b == er_b, "R3", raw_b, er_b);
         check(done_a == ed_a, win_tag, done_a, ed_a);
         check(done_b == ed_b, win_tag, done_b, ed_b);
         check(int'(ones_a) == eo_a, ed_a ? win_tag : "R6", ones_a, eo_a);
         check(int'(ones_b) == eo_b, ed_b ? win_tag : "R6", ones_b, eo_b);
      end
      // expectations after the coming edge
      ha[2] = ha[1]; ha[1] = ha[0]; ha[0] = s;
      hb[1] = hb[0]; hb[0] = s[0];
      if (r) begin
         fa = 0; ev_a = 0; er_a = 0; ed_a = 0; eo_a = 0; cnt_a = 0; tal_a = 0;
         fb = 0; ev_b = 0; er_b = 0; ed_b = 0; eo_b = 0; cnt_b = 0; tal_b = 0;
      end else begin
         pv = ev_a; pr = er_a;
         fa = e ? min_i(fa + 1, SA + 1) : 0;
         ev_a = (fa == SA + 1);
         er_a = ^ha[SA];
         ed_a = 0;
         if (!e) begin cnt_a = 0; tal_a = 0; end
         else if (pv) begin
            tal_a += int'(pr); cnt_a++;
            if (cnt_a == WA) begin ed_a = 1; eo_a = tal_a; cnt_a = 0; tal_a = 0; end
         end
         pv = ev_b; pr = er_b;
         fb = e ? min_i(fb + 1, SB + 1) : 0;
         ev_b = (fb == SB + 1);
         er_b = hb[SB];
         ed_b = 0;
         if (!e) begin cnt_b = 0; tal_b = 0; end
         else if (pv) begin
            tal_b += int'(pr); cnt_b++;
            if (cnt_b == WB) begin ed_b = 1; eo_b = tal_b; cnt_b = 0; tal_b = 0; end
         end
      end
      last_rst = r;
      rst = r; en = e; osc_a = s;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int unsigned seed;
      seed = 32'h5EED_1234;
      void'($urandom(seed));
      for (int i = 0; i < 3; i++) ha[i] = '0;
      for (int i = 0; i < 2; i++) hb[i] = 1'b0;

      // R1: reset state
      for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, '0);
      // R5: all-zero windows give a count of zero
      for (int i = 0; i < 40; i++) cycle(1'b0, 1'b1, '0);
      // R2 R3 R5: all-one inputs, full-scale counts (16 needs every count bit)
      for (int i = 0; i < 50; i++) cycle(1'b0, 1'b1, '1);
      // R2: alternating parity pattern
      for (int i = 0; i < 40; i++) cycle(1'b0, 1'b1, (i % 2) ? 5'b00001 : 5'b00011);
      // R7: enable drop in mid-window discards the partial count
      win_tag = "R7";
      for (int i = 0; i < 10; i++) cycle(1'b0, 1'b1, '1);
      cycle(1'b0, 1'b0, '1);
      for (int i = 0; i < 30; i++) cycle(1'b0, 1'b1, '1);
      cycle(1'b0, 1'b0, '0);
      cycle(1'b0, 1'b0, '0);
      for (int i = 0; i < 25; i++) cycle(1'b0, 1'b1, 5'b10000);
      win_tag = "R5";
      // random traffic with occasional enable drops
      for (int i = 0; i < 1500; i++)
         cycle(1'b0, ($urandom % 32) != 0, NA'($urandom));
      // R1: reset in the middle of a run
      cycle(1'b1, 1'b1, '1);
      cycle(1'b1, 1'b1, '1);
      for (int i = 0; i < 80; i++)
         cycle(1'b0, 1'b1, NA'($urandom));
      finish_run();
   end

endmodule